// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to the two wires of an I2C bus and reports what happens on them, without ever driving either line. A system clock much faster than the bus clock samples SCL and SDA. Both lines pass through a synchroniser. The block then finds the line edges that mark the start and end of a transfer and the clock edges that carry data bits.

Every bus event comes out as a single-cycle pulse on `event_valid`, with an event code, a byte value, a direction flag and an acknowledge flag. The first byte after a START, or after a repeated START, is decoded as the address byte: a 7-bit slave address plus a direction bit. Every later byte in the same transfer is reported as a data byte and carries the direction taken from the address byte.

Typical uses are on-chip bus tracing, protocol checking, and logging by a debug subsystem that shares the wires with a real controller.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A fall of SDA while SCL is high produces a START event (`event_type` 0) with `event_byte`, `event_rw` and `event_nack` all 0. This holds in idle and also in the middle of a transfer, where it acts as a repeated START and begins a new address byte.
- R2: A START or STOP that arrives before a byte's ninth bit discards the bits collected so far and clears the bit counter. No address or data event is produced for that partial byte.
- R3: A rise of SDA while SCL is high produces a STOP event (`event_type` 1) with the other fields 0 and returns the monitor to idle.
- R4: The first complete 9-bit transfer after a START produces an ADDR event (`event_type` 2). `event_byte[6:0]` holds the first seven bits received, most significant bit first, and `event_byte[7]` is 0. `event_rw` is the eighth bit: 0 means write, 1 means read.
- R5: Each later complete 9-bit transfer before the next START or STOP produces a DATA event (`event_type` 3). `event_byte` holds the eight bits, most significant bit first, and `event_rw` repeats the direction bit of the current address byte.
- R6: On ADDR and DATA events, `event_nack` equals the ninth bit of the transfer: 0 is an acknowledge, 1 is a not-acknowledge.
- R7: SCL rising edges while idle, whether before the first START or after a STOP, produce no events.
- R8: `event_valid` is high for exactly one clock per detected event, and each bus event is reported exactly once.
- R9: While `rst_n` is low and after it is released, `event_valid` is 0 until a bus event occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled bus clock line (asynchronous) |
| sda_in | input | 1 | Sampled bus data line (asynchronous) |
| event_valid | output | 1 | One-cycle pulse marking a reported event |
| event_type | output | 2 | 0 START, 1 STOP, 2 ADDR, 3 DATA |
| event_byte | output | 8 | Address (bits 6:0) or data byte |
| event_rw | output | 1 | Direction: 0 write, 1 read |
| event_nack | output | 1 | Ninth bit: 0 ACK, 1 NACK |

## Verification
The hardest case to reach from the ports is a START or STOP that lands part-way through a byte. In that case the bit counter must be cleared without a byte event leaking out. A well-formed bus never produces this, so the stimulus builds it on purpose. Directed sequences clock a few bits and then raise or drop SDA with SCL held high. Random transfers also include repeated STARTs, which put one extra discarded SCL edge into the counter just before each new address byte.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned CNT_W     = $clog2(BYTE_BITS + 2);

  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_STOP  = 2'd1,
    EV_ADDR  = 2'd2,
    EV_DATA  = 2'd3
  } ev_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_DATA
  } mon_state_t;

  // Address field: the seven leading bits, right aligned.
  function automatic logic [BYTE_BITS-1:0] addr_field(input logic [BYTE_BITS-1:0] sh);
    return {1'b0, sh[BYTE_BITS-1:1]};
  endfunction

  // Direction bit: the last bit of the address byte.
  function automatic logic dir_field(input logic [BYTE_BITS-1:0] sh);
    return sh[0];
  endfunction
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int unsigned WIDTH     = 2,
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= {WIDTH{RESET_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic start_seen,
  output logic stop_seen
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise   = !scl_q && scl;
  assign start_seen = scl && sda_q && !sda;
  assign stop_seen  = scl && !sda_q && sda;
endmodule

// File: rtl/i2cmon_frame.sv
module i2cmon_frame
  import i2cmon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_rise,
  input  logic                 sda,
  input  logic                 start_seen,
  input  logic                 stop_seen,
  output logic                 ev_valid,
  output ev_kind_t             ev_kind,
  output logic [BYTE_BITS-1:0] ev_byte,
  output logic                 ev_rw,
  output logic                 ev_nack,
  output mon_state_t           state,
  output logic [CNT_W-1:0]     bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS);

  logic [BYTE_BITS-1:0] shreg;
  logic                 dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      dir_q    <= 1'b0;
      ev_valid <= 1'b0;
      ev_kind  <= EV_START;
      ev_byte  <= '0;
      ev_rw    <= 1'b0;
      ev_nack  <= 1'b0;
    end else begin
      ev_valid <= 1'b0;
      if (start_seen || stop_seen) begin
        state    <= start_seen ? ST_START : ST_IDLE;
        bit_cnt  <= '0;
        ev_valid <= 1'b1;
        ev_kind  <= start_seen ? EV_START : EV_STOP;
        ev_byte  <= '0;
        ev_rw    <= 1'b0;
        ev_nack  <= 1'b0;
      end else if (scl_rise && state != ST_IDLE) begin
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          ev_valid <= 1'b1;
          ev_nack  <= sda;
          state    <= ST_DATA;
          if (state == ST_DATA) begin
            ev_kind <= EV_DATA;
            ev_byte <= shreg;
            ev_rw   <= dir_q;
          end else begin
            ev_kind <= EV_ADDR;
            ev_byte <= addr_field(shreg);
            ev_rw   <= dir_field(shreg);
            dir_q   <= dir_field(shreg);
          end
        end else begin
          shreg   <= {shreg[BYTE_BITS-2:0], sda};
          bit_cnt <= bit_cnt + CNT_W'(1);
          if (state == ST_START) state <= ST_ADDR;
        end
      end
    end
  end

  // R2: a line condition always leaves the bit counter empty
  a_r2_cond_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen || stop_seen) |=> (bit_cnt == '0));

  // R2: counter never runs past the acknowledge slot
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);

  // R7: idle stays idle and silent unless a line condition occurs
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start_seen && !stop_seen) |=> (!ev_valid && state == ST_IDLE));

  // R4: an address report moves the decoder into the data phase
  a_r4_addr_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EV_ADDR) |-> (state == ST_DATA));

  // R5: byte reports only follow a ninth clock edge
  a_r5_byte_after_ninth: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && (ev_kind == EV_ADDR || ev_kind == EV_DATA))
      |-> ($past(bit_cnt) == LAST && $past(scl_rise)));
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       event_valid,
  output logic [1:0] event_type,
  output logic [7:0] event_byte,
  output logic       event_rw,
  output logic       event_nack
);
  logic [1:0]       lines_s;
  logic             scl_s, sda_s;
  logic             scl_rise, start_seen, stop_seen;
  ev_kind_t         ev_kind;
  mon_state_t       mon_state;
  logic [CNT_W-1:0] bit_cnt;

  i2cmon_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cmon_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_rise), .start_seen(start_seen), .stop_seen(stop_seen)
  );

  i2cmon_frame u_frame (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .sda(sda_s),
    .start_seen(start_seen), .stop_seen(stop_seen),
    .ev_valid(event_valid), .ev_kind(ev_kind), .ev_byte(event_byte),
    .ev_rw(event_rw), .ev_nack(event_nack),
    .state(mon_state), .bit_cnt(bit_cnt)
  );
  assign event_type = ev_kind;

  // R1: a detected start condition is reported on the next clock
  a_r1_start_reported: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (event_valid && event_type == 2'd0));

  // R3: a detected stop is reported and the decoder goes idle
  a_r3_stop_reported: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (event_valid && event_type == 2'd1 && mon_state == ST_IDLE));

  // R1: start and stop events carry no payload
  a_r1_cond_payload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (event_valid && event_type[1] == 1'b0) |-> (event_byte == 8'd0 && !event_rw && !event_nack));
endmodule

// File: tb/i2c_bus_monitor_tb.sv
`timescale 1ns/1ps
module i2c_bus_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic       event_valid;
  logic [1:0] event_type;
  logic [7:0] event_byte;
  logic       event_rw;
  logic       event_nack;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [11:0] obs_q[$];
  logic [11:0] exp_q[$];
  logic        cur_dir = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bus_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .event_valid(event_valid), .event_type(event_type), .event_byte(event_byte),
    .event_rw(event_rw), .event_nack(event_nack)
  );

  always @(negedge clk)
    if (rst_n && event_valid) obs_q.push_back({event_type, event_byte, event_rw, event_nack});

  function automatic logic [11:0] ev_pack(input logic [1:0] t, input logic [7:0] b,
                                          input logic rw, input logic nk);
    return {t, b, rw, nk};
  endfunction

  function automatic string tag_of(input logic [1:0] t);
    case (t)
      2'd0: return "R1";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic c, input logic d);
    scl_in = c;
    sda_in = d;
    step();
  endtask

  task automatic bus_start();
    if (!(scl_in && sda_in)) begin
      drive(1'b0, sda_in);
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
    end
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    exp_q.push_back(ev_pack(2'd0, 8'd0, 1'b0, 1'b0));
  endtask

  task automatic bus_stop();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    exp_q.push_back(ev_pack(2'd1, 8'd0, 1'b0, 1'b0));
  endtask

  task automatic send_bit(input logic b);
    drive(1'b0, b);
    drive(1'b1, b);
    drive(1'b0, b);
  endtask

  task automatic send_raw(input logic [7:0] b, input logic nk);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    send_bit(nk);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rd, input logic nk);
    send_raw({a, rd}, nk);
    cur_dir = rd;
    exp_q.push_back(ev_pack(2'd2, {1'b0, a}, rd, nk));
  endtask

  task automatic send_data(input logic [7:0] b, input logic nk);
    send_raw(b, nk);
    exp_q.push_back(ev_pack(2'd3, b, cur_dir, nk));
  endtask

  task automatic compare_q(input string req);
    int n;
    step();
    step();
    check(obs_q.size() == exp_q.size(), req, 12'(obs_q.size()), 12'(exp_q.size()));
    n = (obs_q.size() < exp_q.size()) ? obs_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      check(obs_q[i][11:1] == exp_q[i][11:1], tag_of(exp_q[i][11:10]), obs_q[i], exp_q[i]);
      check(obs_q[i][0] == exp_q[i][0], "R6", obs_q[i], exp_q[i]);
    end
    obs_q.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd13579));
    repeat (3) @(posedge clk);
    #1;
    check(event_valid == 1'b0, "R9", 12'(event_valid), 12'd0);
    rst_n = 1'b1;
    step();
    check(event_valid == 1'b0 && obs_q.size() == 0, "R9", 12'(obs_q.size()), 12'd0);

    // R7: clock pulses before any START
    for (int i = 0; i < 6; i++) send_bit(logic'(i[0]));
    compare_q("R7");

    // R4 R5 R6: write transfer
    bus_start();
    send_addr(7'h50, 1'b0, 1'b0);
    send_data(8'hA5, 1'b0);
    send_data(8'h00, 1'b1);
    bus_stop();
    compare_q("R8");

    // R1: repeated START switching to a read
    bus_start();
    send_addr(7'h7F, 1'b0, 1'b0);
    send_data(8'hFF, 1'b0);
    bus_start();
    send_addr(7'h01, 1'b1, 1'b0);
    send_data(8'h3C, 1'b1);
    bus_stop();
    compare_q("R1");

    // R2: STOP in the middle of a byte, then R7 after STOP
    bus_start();
    send_addr(7'h2A, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    for (int i = 0; i < 9; i++) send_bit(logic'(i[1]));
    compare_q("R2");

    // R2: START in the middle of the address byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_addr(7'h11, 1'b0, 1'b0);
    bus_stop();
    compare_q("R2");

    // Random transfers
    for (int t = 0; t < 30; t++) begin
      int nb;
      bus_start();
      send_addr(7'($urandom), 1'($urandom), 1'($urandom));
      nb = int'($urandom % 5);
      for (int k = 0; k < nb; k++) send_data(8'($urandom), 1'($urandom));
      if (($urandom % 4) == 0) begin
        bus_start();
        send_addr(7'($urandom), 1'($urandom), 1'($urandom));
        send_data(8'($urandom), 1'($urandom));
      end
      bus_stop();
      compare_q("R8");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule